// File: doc/BRIEF.md
# Serial Shift Register with Parallel Hold Stage

This block collects a serial bit stream into a chain of shift stages and, on command, copies the whole chain in parallel into a separate hold register whose outputs drive downstream logic. The shift chain and the hold register each have their own clock strobe and their own active-low clear. Because of this, new data can be shifted in while the hold outputs keep showing the previous word. The last shift stage is also brought out as a serial cascade bit, so several blocks can be chained in series.

The strobes and clears are asynchronous level inputs. They are sampled into a single system clock domain through two-flop synchronizers, and a rising edge on a strobe is turned into a one-cycle action. The serial input goes through the same two-flop path, so it stays aligned with the shift strobe. The parameter `LANES` sets how many 8-bit lanes are chained. Lane k takes its serial input from the cascade bit of lane k-1, and all lanes share the strobes and clears.

Top module: `shift_hold_reg`

## Requirements
- R1: A synchronous active-high `rst` sets every shift stage, every hold bit and `cascade_out` to 0.
- R2: A rising edge of `sh_clk` with `sh_clr_n` high loads `ser_in` into shift stage 0 and moves each stage i into stage i+1.
- R3: A falling edge of `sh_clk` changes no shift stage, and a falling edge of `st_clk` changes no hold bit. The hold register changes only on a rising edge of `st_clk` or on `st_clr_n` low.
- R4: While `sh_clr_n` is low, all shift stages read 0 and `sh_clk` edges and `ser_in` have no effect.
- R5: While `st_clr_n` is low, `par_out` is 0 and `st_clk` edges have no effect.
- R6: A rising edge of `st_clk` with `st_clr_n` high copies all shift stages into `par_out`, with stage i appearing on `par_out[i]`.
- R7: `cascade_out` equals the last shift stage (index 8*LANES-1). It changes only on a rising edge of `sh_clk` or on `sh_clr_n` low, and never because of `st_clk` or `st_clr_n`.
- R8: When rising edges of `sh_clk` and `st_clk` arrive in the same system cycle, the hold register takes the contents from before that shift, so it stays one shift behind.
- R9: A strobe edge that is detected in the same system cycle in which that register's clear is released is dropped.
- R10: With `LANES` lanes the chain is 8*LANES stages long. After 8*LANES shifts, the first bit shifted in ends up on `par_out[8*LANES-1]` and the last one on `par_out[0]`.
- R11: An input change becomes visible on the outputs on the third rising `clk` edge after it is sampled.

Ports in the order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift strobe; rising edge shifts |
| sh_clr_n | input | 1 | Active-low clear of the shift chain |
| st_clk | input | 1 | Hold strobe; rising edge copies the chain |
| st_clr_n | input | 1 | Active-low clear of the hold register |
| par_out | output | 8*LANES | Hold register outputs, bit i from stage i |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The assertions assume that the strobes and clears change only at system-clock granularity, and that each level is held for at least a few cycles so that the three-cycle path from pin to register is well defined. The stimulus keeps to this: it changes inputs only at falling `clk` edges and holds every strobe and clear level for four cycles. `ser_in` is set one phase before the shift strobe rises and is held until after it falls, so data and strobe pass through the synchronizers in step.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int LANE_W = 8;

    // Per-register command derived from synchronized strobe and clear.
    typedef struct packed {
        logic clr;      // register forced to zero this cycle
        logic edge_ok;  // apply one shift or capture this cycle
    } reg_cmd_t;

    // An edge is only honoured when the clear is inactive both now and
    // in the previous sample, so a releasing clear swallows the edge.
    function automatic reg_cmd_t make_cmd(input logic strobe_now,
                                          input logic strobe_prev,
                                          input logic clr_now_n,
                                          input logic clr_prev_n);
        reg_cmd_t c;
        c.clr     = ~clr_now_n;
        c.edge_ok = strobe_now & ~strobe_prev & clr_now_n & clr_prev_n;
        return c;
    endfunction

endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/shift_lane.sv
module shift_lane
    import shreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic              din,
    output logic [LANE_W-1:0] q,
    output logic              cas
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            q <= '0;
        end else if (cmd.edge_ok) begin
            q <= {q[LANE_W-2:0], din};
        end
    end

    assign cas = q[LANE_W-1];
endmodule

// File: rtl/hold_reg.sv
module hold_reg
    import shreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_cmd_t     cmd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clr) begin
            q <= '0;
        end else if (cmd.edge_ok) begin
            q <= d;
        end
    end
endmodule

// File: rtl/shift_hold_reg.sv
module shift_hold_reg
    import shreg_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_in,
    input  logic                    sh_clk,
    input  logic                    sh_clr_n,
    input  logic                    st_clk,
    input  logic                    st_clr_n,
    output logic [LANES*LANE_W-1:0] par_out,
    output logic                    cascade_out
);
    localparam int NBITS  = LANES * LANE_W;
    localparam int NCTL   = 4;
    localparam int I_SHC  = 0;
    localparam int I_SHR  = 1;
    localparam int I_STC  = 2;
    localparam int I_STR  = 3;

    logic [NCTL:0]   sync_q;
    logic [NCTL-1:0] ctl_prev;
    logic            ser_s;
    reg_cmd_t        sh_cmd;
    reg_cmd_t        st_cmd;
    logic [NBITS-1:0] sh_bits;
    logic [LANES:0]  link;

    // Bit NCTL carries serial data; lower bits carry strobes and clears.
    sync2 #(.W(NCTL + 1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({ser_in, st_clr_n, st_clk, sh_clr_n, sh_clk}),
        .q_sync  (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= '0;
        else     ctl_prev <= sync_q[NCTL-1:0];
    end

    assign ser_s  = sync_q[NCTL];
    assign sh_cmd = make_cmd(sync_q[I_SHC], ctl_prev[I_SHC],
                             sync_q[I_SHR], ctl_prev[I_SHR]);
    assign st_cmd = make_cmd(sync_q[I_STC], ctl_prev[I_STC],
                             sync_q[I_STR], ctl_prev[I_STR]);

    assign link[0] = ser_s;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        shift_lane u_lane (
            .clk (clk),
            .rst (rst),
            .cmd (sh_cmd),
            .din (link[g]),
            .q   (sh_bits[g*LANE_W +: LANE_W]),
            .cas (link[g+1])
        );
    end

    // Capture uses the chain value before this cycle's shift.
    hold_reg #(.W(NBITS)) u_hold (
        .clk (clk),
        .rst (rst),
        .cmd (st_cmd),
        .d   (sh_bits),
        .q   (par_out)
    );

    assign cascade_out = link[LANES];
endmodule

// File: rtl/shift_hold_chk.sv
module shift_hold_chk #(
    parameter int NB = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          sh_clk,
    input logic          sh_clr_n,
    input logic          st_clk,
    input logic          st_clr_n,
    input logic [NB-1:0] par_out,
    input logic          cascade_out
);
    logic [2:0] age;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end
    assign ready = (age >= 3'd5);

    // R1: outputs are zero the cycle after reset is sampled
    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (par_out == '0 && cascade_out == 1'b0));

    // R4 and R11: shift clear three cycles back forces cascade low
    a_r4_shift_clear: assert property (@(posedge clk) disable iff (rst)
        (ready && !$past(sh_clr_n, 3)) |-> cascade_out == 1'b0);

    // R5 and R11: hold clear three cycles back forces outputs low
    a_r5_hold_clear: assert property (@(posedge clk) disable iff (rst)
        (ready && !$past(st_clr_n, 3)) |-> par_out == '0);

    // R3: hold register moves only on a strobe rise or clear
    a_r3_hold_cause: assert property (@(posedge clk) disable iff (rst)
        (ready && !$stable(par_out)) |->
        (($past(st_clk, 3) && !$past(st_clk, 4)) || !$past(st_clr_n, 3)));

    // R7: cascade moves only on a shift rise or shift clear
    a_r7_cascade_cause: assert property (@(posedge clk) disable iff (rst)
        (ready && !$stable(cascade_out)) |->
        (($past(sh_clk, 3) && !$past(sh_clk, 4)) || !$past(sh_clr_n, 3)));
endmodule

bind shift_hold_reg shift_hold_chk #(.NB(LANES * shreg_pkg::LANE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sh_clk      (sh_clk),
    .sh_clr_n    (sh_clr_n),
    .st_clk      (st_clk),
    .st_clr_n    (st_clr_n),
    .par_out     (par_out),
    .cascade_out (cascade_out)
);

// File: tb/tb_shift_hold_reg.sv
`timescale 1ns/1ps
module tb_shift_hold_reg;
    localparam int LANES = 2;
    localparam int NB    = LANES * 8;
    localparam int PH    = 4;

    // op: 0 shift, 1 capture, 2 shift+capture together, 3 pulse hold clear
    localparam int NVEC = 14;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b001, 3'b000, 3'b001, 3'b001, 3'b010, 3'b000, 3'b101,
        3'b010, 3'b001, 3'b110, 3'b011, 3'b010, 3'b001, 3'b100
    };

    logic clk = 1'b0;
    logic rst, ser_in, sh_clk, sh_clr_n, st_clk, st_clr_n;
    logic [NB-1:0] par_out;
    logic cascade_out;

    logic [NB-1:0] m_sh, m_st;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shift_hold_reg #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .sh_clk(sh_clk),
        .sh_clr_n(sh_clr_n), .st_clk(st_clk), .st_clr_n(st_clr_n),
        .par_out(par_out), .cascade_out(cascade_out)
    );

    task automatic wait_ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NB-1:0] exp_par,
                         input logic exp_cas);
        checks++;
        if (par_out !== exp_par || cascade_out !== exp_cas) begin
            errors++;
            $display("FAIL %s: par_out=%h cascade=%b expected par_out=%h cascade=%b",
                     req, par_out, cascade_out, exp_par, exp_cas);
        end
    endtask

    task automatic do_shift(input logic b, input string req);
        ser_in = b; wait_ph();
        sh_clk = 1'b1; wait_ph();
        m_sh = {m_sh[NB-2:0], b};
        check(req, m_st, m_sh[NB-1]);
        sh_clk = 1'b0; wait_ph();
        check("R3 shift fall", m_st, m_sh[NB-1]);
    endtask

    task automatic do_capture(input string req);
        st_clk = 1'b1; wait_ph();
        m_st = m_sh;
        check(req, m_st, m_sh[NB-1]);
        st_clk = 1'b0; wait_ph();
        check("R3 hold fall", m_st, m_sh[NB-1]);
    endtask

    task automatic do_both(input logic b);
        ser_in = b; wait_ph();
        sh_clk = 1'b1; st_clk = 1'b1; wait_ph();
        m_st = m_sh;
        m_sh = {m_sh[NB-2:0], b};
        check("R8 tied strobes", m_st, m_sh[NB-1]);
        sh_clk = 1'b0; st_clk = 1'b0; wait_ph();
    endtask

    initial begin
        rst = 1'b1; ser_in = 0; sh_clk = 0; st_clk = 0;
        sh_clr_n = 1'b1; st_clr_n = 1'b1;
        m_sh = '0; m_st = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", '0, 1'b0);
        wait_ph(); wait_ph();

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][2:1])
                2'd0: do_shift(VEC[i][0], "R2 shift");
                2'd1: do_capture("R6 capture");
                2'd2: do_both(VEC[i][0]);
                default: begin
                    st_clr_n = 1'b0; wait_ph();
                    m_st = '0;
                    check("R5 hold clear, R7 cascade kept", m_st, m_sh[NB-1]);
                    st_clr_n = 1'b1; wait_ph();
                end
            endcase
        end

        // R10: full-length word, first bit lands on top
        begin
            logic [NB-1:0] pat;
            pat = 16'hA5C3;
            for (int k = NB - 1; k >= 0; k--) do_shift(pat[k], "R2 word fill");
            do_capture("R10 word order");
            check("R10 par_out equals word", pat, pat[NB-1]);
            do_shift(1'b0, "R7 cascade after extra shift");
            check("R7 cascade is next bit", pat, pat[NB-2]);
        end

        // R5: hold clear overrides a capture strobe; cascade unaffected
        st_clr_n = 1'b0; wait_ph();
        st_clk = 1'b1; wait_ph();
        check("R5 capture ignored under clear", '0, m_sh[NB-1]);
        st_clk = 1'b0; st_clr_n = 1'b1; wait_ph(); wait_ph();
        m_st = '0;
        check("R5 hold stays clear after release", m_st, m_sh[NB-1]);

        // R4: shift clear overrides strobe and data
        sh_clr_n = 1'b0; ser_in = 1'b1; wait_ph();
        m_sh = '0;
        sh_clk = 1'b1; wait_ph();
        check("R4 shift clear holds zero", m_st, 1'b0);
        sh_clk = 1'b0; wait_ph();
        sh_clr_n = 1'b1; wait_ph(); wait_ph();
        do_capture("R4 chain empty after clear");

        // R9: edge coinciding with clear release is dropped
        sh_clr_n = 1'b0; ser_in = 1'b1; wait_ph();
        sh_clr_n = 1'b1; sh_clk = 1'b1; wait_ph();
        sh_clk = 1'b0; wait_ph();
        check("R9 edge at release dropped", m_st, 1'b0);
        do_capture("R9 chain still empty");

        // R11: action visible on third edge after sampling
        ser_in = 1'b1; wait_ph();
        sh_clk = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 not yet shifted", m_st, m_sh[NB-1]);
        wait_ph();
        m_sh = {m_sh[NB-2:0], 1'b1};
        sh_clk = 1'b0; wait_ph();
        do_capture("R11 shift landed");

        // R1: reset in mid-run clears everything
        rst = 1'b1; @(negedge clk); @(negedge clk);
        rst = 1'b0; m_sh = '0; m_st = '0;
        check("R1 reset mid-run", '0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule